// File: doc/BRIEF.md
# Eight-to-one serializer with start synchronization

The block turns an 8-bit parallel word into a serial bit stream at the bit-clock rate. It takes in one word every eight bit-clock cycles and sends it out least significant bit first. Words follow one another with no idle bit between them. It also produces a divided parallel-side clock at one eighth of the bit rate. The rising edge of that clock marks the edge on which a word is taken in, so upstream logic can change the next word on its falling edge.

A high level on the `sync` control input clears all state at once, without waiting for a clock edge, and holds both outputs low. The release of `sync` passes through a synchronizer clocked on the falling edge of the bit clock. After `sync` falls, the block waits for a falling clock edge and then takes in the first word on the rising edge that follows. A restart therefore always begins on a whole bit period, with the first bit of a freshly taken word.

The data path has a fixed rate with no back-pressure. The parallel side is paced by `par_clk` and has no valid/ready handshake: upstream must present a word before every rising edge of `par_clk`, and the block never stalls.

Top module: `ser8_serializer`

## Requirements
- R1: While running, `par_clk` has a period of 8 bit-clock cycles. It goes high on each word-latch edge, stays high for 4 cycles and stays low for 4 cycles.
- R2: A rising edge on `sync` drives `ser_out` and `par_clk` low at once, without a bit-clock edge, even in the middle of a word.
- R3: While `sync` is high, `ser_out` and `par_clk` stay 0 and changes on `par_data` have no effect on the outputs.
- R4: After `sync` falls, the first word is latched on the first rising `clk` edge that follows a falling `clk` edge seen after the release. A rising edge that comes before that falling edge latches nothing and leaves `par_clk` low.
- R5: The bits of each word leave in the order `par_data[0]` first through `par_data[7]` last. The next word's bit 0 follows `par_data[7]` of the previous word directly, with no gap.
- R6: The bit `par_data[0]` of a latched word appears on `ser_out` after the rising edge that follows the latch edge, a latency of 1 bit-clock cycle. Each bit is held for exactly one bit period. Before the first word, `ser_out` is 0.
- R7: After a restart, the first bit sent is bit 0 of the first word latched after the release, followed by the remaining seven bits in full. No shortened or partial bit is sent.
- R8: The word is sampled on the rising edge of `clk` at which `par_clk` rises. Changing `par_data` after that edge does not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| sync | input | 1 | Active high; clears asynchronously when it goes high, restart is synchronized after it falls |
| par_data | input | 8 | Parallel word, sampled on the rising edge of `par_clk` |
| ser_out | output | 1 | Serial data, bit 0 of each word first |
| par_clk | output | 1 | Parallel-side clock at one eighth of the bit rate; its rising edge marks each latch |

## Verification
On every cycle, the assertions check that both outputs stay low while `sync` is high, that `par_clk` keeps its 8-cycle period and its 4-cycle high time, and that each frame's first serial bit equals bit 0 of the word sampled at the latch edge. The bench scenarios show the behaviour that no single-cycle property can capture. These are the clearing of the outputs between clock edges when `sync` rises, the release timing when `sync` falls in the low phase of the clock, and the bit order across back-to-back words. They also cover the complete first word after a restart and the fact that `par_data` changes after the latch edge do not reach the word being sent.

// File: rtl/ser8_pkg.sv
`timescale 1ns/1ps
package ser8_pkg;

  typedef int unsigned uint_t;

  localparam uint_t DEF_WORD_W = 8;

  // parallel clock is high during the first half of each frame
  function automatic logic frame_high_half(input uint_t pos, input uint_t word_w);
    return (pos < (word_w / 2));
  endfunction

endpackage

// File: rtl/ser8_sync_release.sv
`timescale 1ns/1ps
// Start enable: cleared at once by sync, set again through falling-edge flops.
module ser8_sync_release #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic sync,
  output logic run_en
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(negedge clk or posedge sync) begin
        if (sync) chain <= 1'b0;
        else      chain <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(negedge clk or posedge sync) begin
        if (sync) chain <= '0;
        else      chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign run_en = chain[STAGES-1];

endmodule

// File: rtl/ser8_frame_ctrl.sv
`timescale 1ns/1ps
// Bit position counter, latch strobe and divided parallel clock.
module ser8_frame_ctrl
  import ser8_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic clk,
  input  logic sync,
  input  logic run_en,
  output logic load,
  output logic par_clk
);

  localparam int unsigned     CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] pos;
  logic             pclk_q;

  always_ff @(posedge clk or posedge sync) begin
    if (sync) begin
      pos    <= '0;
      pclk_q <= 1'b0;
    end else if (run_en) begin
      pos    <= (pos == LAST) ? '0 : pos + CNT_W'(1);
      pclk_q <= frame_high_half(uint_t'(pos), WORD_W);
    end
  end

  assign load    = run_en && (pos == '0);
  assign par_clk = pclk_q;

endmodule

// File: rtl/ser8_shift_out.sv
`timescale 1ns/1ps
// Word register shifting toward bit 0, followed by output retiming flops.
module ser8_shift_out
  import ser8_pkg::*;
#(
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned OUT_STAGES = 1
) (
  input  logic              clk,
  input  logic              sync,
  input  logic              run_en,
  input  logic              load,
  input  logic [WORD_W-1:0] par_data,
  output logic              ser_out
);

  logic [WORD_W-1:0]     sh;
  logic [OUT_STAGES-1:0] pipe;

  always_ff @(posedge clk or posedge sync) begin
    if (sync)        sh <= '0;
    else if (load)   sh <= par_data;
    else if (run_en) sh <= {1'b0, sh[WORD_W-1:1]};
  end

  generate
    if (OUT_STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge sync) begin
        if (sync) pipe <= 1'b0;
        else      pipe <= sh[0];
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge sync) begin
        if (sync) pipe <= '0;
        else      pipe <= {pipe[OUT_STAGES-2:0], sh[0]};
      end
    end
  endgenerate

  assign ser_out = pipe[OUT_STAGES-1];

endmodule

// File: rtl/ser8_serializer.sv
`timescale 1ns/1ps
module ser8_serializer
  import ser8_pkg::*;
#(
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned SYNC_STAGES = 1,
  parameter int unsigned OUT_STAGES  = 1
) (
  input  logic              clk,
  input  logic              sync,
  input  logic [WORD_W-1:0] par_data,
  output logic              ser_out,
  output logic              par_clk
);

  logic run_en;
  logic load;

  ser8_sync_release #(.STAGES(SYNC_STAGES)) u_rel (
    .clk    (clk),
    .sync   (sync),
    .run_en (run_en)
  );

  ser8_frame_ctrl #(.WORD_W(WORD_W)) u_frame (
    .clk     (clk),
    .sync    (sync),
    .run_en  (run_en),
    .load    (load),
    .par_clk (par_clk)
  );

  ser8_shift_out #(.WORD_W(WORD_W), .OUT_STAGES(OUT_STAGES)) u_shift (
    .clk      (clk),
    .sync     (sync),
    .run_en   (run_en),
    .load     (load),
    .par_data (par_data),
    .ser_out  (ser_out)
  );

endmodule

// File: rtl/ser8_serializer_chk.sv
`timescale 1ns/1ps
module ser8_serializer_chk #(
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned OUT_STAGES = 1
) (
  input logic              clk,
  input logic              sync,
  input logic [WORD_W-1:0] par_data,
  input logic              ser_out,
  input logic              par_clk
);

  logic        prev_pclk;
  logic        have_rise;
  int unsigned since_rise;

  always_ff @(posedge clk or posedge sync) begin
    if (sync) begin
      prev_pclk  <= 1'b0;
      have_rise  <= 1'b0;
      since_rise <= 0;
    end else begin
      prev_pclk <= par_clk;
      if (par_clk && !prev_pclk) begin
        since_rise <= 1;
        have_rise  <= 1'b1;
      end else begin
        since_rise <= since_rise + 1;
      end
    end
  end

  // R3: outputs held low while sync is high
  always @(negedge clk) begin
    if (sync === 1'b1) begin
      p_hold_low_r3: assert (ser_out == 1'b0 && par_clk == 1'b0);
    end
  end

  // R1: rising edges of par_clk are a full frame apart
  p_pclk_period_r1: assert property (@(posedge clk) disable iff (sync)
    (par_clk && !prev_pclk && have_rise) |-> (since_rise == WORD_W));

  // R1: high time of par_clk is half a frame
  p_pclk_high_r1: assert property (@(posedge clk) disable iff (sync)
    (!par_clk && prev_pclk) |-> (since_rise == WORD_W / 2));

  generate
    if (OUT_STAGES == 1) begin : g_lat
      // R6: bit 0 of the word sampled at the latch edge leads the frame
      p_first_bit_r6: assert property (@(posedge clk) disable iff (sync)
        $rose(par_clk) |=> (ser_out == $past(par_data[0], 2)));
    end
  endgenerate

endmodule

bind ser8_serializer ser8_serializer_chk #(
  .WORD_W     (WORD_W),
  .OUT_STAGES (OUT_STAGES)
) u_chk (
  .clk      (clk),
  .sync     (sync),
  .par_data (par_data),
  .ser_out  (ser_out),
  .par_clk  (par_clk)
);

// File: tb/ser8_serializer_tb.sv
`timescale 1ns/1ps
module ser8_serializer_tb;

  localparam int NV = 8;
  // {parallel word, serial stream with the first emitted bit in bit 7}
  localparam logic [15:0] VEC [NV] = '{
    {8'hA5, 8'hA5}, {8'h01, 8'h80}, {8'h80, 8'h01}, {8'hF0, 8'h0F},
    {8'h3C, 8'h3C}, {8'hC5, 8'hA3}, {8'h6E, 8'h76}, {8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       sync;
  logic [7:0] par_data;
  logic       ser_out;
  logic       par_clk;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  ser8_serializer u_dut (
    .clk      (clk),
    .sync     (sync),
    .par_data (par_data),
    .ser_out  (ser_out),
    .par_clk  (par_clk)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    sync     = 1'b0;
    par_data = VEC[0][15:8];
    #1 sync  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 reset ser_out", ser_out, 1'b0);
    chk("R3 reset par_clk", par_clk, 1'b0);

    // release while clk high; latch on the rising edge after next fall
    @(posedge clk);
    #5 sync = 1'b0;
    @(posedge clk);                      // latch edge of word 0
    for (int t = 0; t <= 8 * NV; t++) begin
      if (t > 0) @(posedge clk);
      @(negedge clk);
      chk("R1/R8 par_clk phase", par_clk, ((t % 8) < 4));
      if (t == 0) begin
        chk("R6 ser_out before first bit", ser_out, 1'b0);
      end else begin
        chk("R5 serial bit order", ser_out, VEC[(t-1)/8][7 - ((t-1) % 8)]);
      end
      if ((t % 8) == 4) begin
        par_data = ((t / 8 + 1) < NV) ? VEC[t/8 + 1][15:8] : 8'hFF;
      end
    end

    // async clear in mid-frame: word FF is being sent, par_clk high
    @(posedge clk);
    #2 chk("R5 precondition ser_out high", ser_out, 1'b1);
    chk("R1 precondition par_clk high", par_clk, 1'b1);
    #1 sync = 1'b1;
    #1 chk("R2 async clear ser_out", ser_out, 1'b0);
    chk("R2 async clear par_clk", par_clk, 1'b0);

    // held low; data changes ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      par_data = (i % 2 == 0) ? 8'hAA : 8'h55;
      @(negedge clk);
      chk("R3 hold ser_out", ser_out, 1'b0);
      chk("R3 hold par_clk", par_clk, 1'b0);
    end

    // release while clk low: first rising edge must not latch
    @(negedge clk);
    par_data = 8'h01;
    #3 sync = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R4 no latch before falling edge par_clk", par_clk, 1'b0);
    chk("R4 no latch before falling edge ser_out", ser_out, 1'b0);
    @(posedge clk);                      // latch edge
    @(negedge clk);
    chk("R4 latch par_clk", par_clk, 1'b1);
    chk("R6 latency not yet", ser_out, 1'b0);
    par_data = 8'hFE;                    // change after latch: must not matter
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk("R7/R8 full first word after restart", ser_out, (j == 0));
    end
    @(negedge clk);
    chk("R8 next word takes new data", ser_out, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule